// File: doc/BRIEF.md
# Plug-and-Play Configuration Port Controller

This block is the configuration front end of a legacy-style multi-function peripheral controller that sits on a simple byte-wide host I/O bus. After reset it is locked, and the only thing it reacts to is a four-byte unlock key written to the fixed key port at 0x2E. The last byte of the key chooses where the index/data register pair appears. With 0x55 the index port is 0x2E. With 0xAA it is 0x4E. The data port is always the next address up.

While unlocked, firmware writes a register index to the index port and then reads or writes the selected register through the data port. Indices below 0x30 reach global registers: the logical device number, a chip-select compare against a jumper, a clock-rate select, a suspend flag and the write-only configure-control register. Indices at 0x30 and above reach the bank of the logical device that was last written into the device-number register. Each bank holds an activate bit, and that bit drives one enable output. Writing the exit command to configure control locks the block again.

Top module: `pnp_cfg_port`

## Requirements
- R1: Writing 0x87, 0x01, 0x55 and then a final byte of 0x55 or 0xAA to address 0x2E while locked sets cfgActive high on the clock edge that captures the final byte.
- R2: A final key byte of 0x55 maps the index port to 0x2E and the data port to 0x2F. A final byte of 0xAA maps them to 0x4E and 0x4F, and the other pair is then not decoded (reads return 0xFF). Any other final byte leaves the block locked.
- R3: A key byte that does not match makes key matching start over. If that byte is 0x87, it counts as the first key byte, so matching continues at the second byte.
- R4: While locked, writes to the index and data ports change no register, and every read returns 0xFF.
- R5: Index 0x07 holds the logical device number and reads back as written. Index 0x30 reaches the activate register of the bank named by that number. Bit 0 of the activate register drives devEnable[number], and a read returns {7'b0, bit}.
- R6: Writing 0x02 to index 0x02 locks the block on the next clock edge. Other values written there have no effect. Reading index 0x02 returns 0x00.
- R7: Index 0x22 bit 7 is a chip-select bit compared against jumperSel. Until index 0x22 has been written after reset, all accesses are accepted. After that, data-port accesses to indices other than 0x02 and 0x22 are ignored, and data reads return 0xFF, unless bit 7 equals jumperSel. Writes to 0x02 and 0x22 are always accepted.
- R8: Index 0x23 bit 0 drives clkSel. Index 0x24 bit 0 drives suspendFlag. Both read back in bit 0.
- R9: Unimplemented indices read 0xFF. When the device number is NUM_DEV or greater, banked reads return 0xFF and banked writes change no enable.
- R10: Reset clears every enable bit, the device number, clkSel and the chip-select state, sets suspendFlag to 1, and leaves the block locked.
- R11: A read of the index port while unlocked returns the current index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioAddr | input | ADDR_W | Host I/O address |
| ioWr | input | 1 | Write strobe, one cycle per byte |
| ioRd | input | 1 | Read strobe |
| ioWdata | input | 8 | Write data |
| ioRdata | output | 8 | Read data, combinational, 0xFF when nothing is decoded |
| jumperSel | input | 1 | Strap level compared with the chip-select bit |
| devEnable | output | NUM_DEV | Per-device activate outputs |
| cfgActive | output | 1 | High while configuration mode is open |
| clkSel | output | 1 | Input clock rate select |
| suspendFlag | output | 1 | Software suspend flag |

## Verification
The bench aims at the key matcher's recovery paths. It sends a repeated 0x87 in the middle of the key, a wrong byte in the third position, and a bad final byte. A matcher that always falls back to the first byte would stay locked on the first of these, and one that does not fall back at all would unlock on the others. It checks the alternate base, where a decoder that ignores the key's last byte would still answer at 0x2F. It drives out-of-range device numbers, where a careless bank index would switch on a real enable. It deselects the chip with the jumper and confirms that the exit command still gets through. A design that gates configure control with chip select would be stuck in configuration mode. The bench also confirms that writes made while locked leave the device number untouched.

// File: rtl/pnp_cfg_pkg.sv
package pnp_cfg_pkg;

  // strobes from the bus decoder to the register datapath
  typedef struct packed {
    logic idxWr;
    logic idxRd;
    logic dataWr;
    logic dataRd;
  } cfgStrobe_t;

  localparam logic [7:0] IDX_CTRL = 8'h02;
  localparam logic [7:0] IDX_LDN  = 8'h07;
  localparam logic [7:0] IDX_CS   = 8'h22;
  localparam logic [7:0] IDX_CLK  = 8'h23;
  localparam logic [7:0] IDX_SUSP = 8'h24;
  localparam logic [7:0] IDX_ACT  = 8'h30;
  localparam logic [7:0] EXIT_CMD = 8'h02;

  localparam logic [7:0] KEY_B0   = 8'h87;
  localparam logic [7:0] KEY_B1   = 8'h01;
  localparam logic [7:0] KEY_B2   = 8'h55;
  localparam logic [7:0] KEY_LOW  = 8'h55;
  localparam logic [7:0] KEY_HIGH = 8'hAA;

endpackage

// File: rtl/pnp_cfg_ctrl.sv
module pnp_cfg_ctrl
  import pnp_cfg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] KEY_PORT = 16'h002E,
  parameter logic [ADDR_W-1:0] ALT_PORT = 16'h004E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [7:0]        ioWdata,
  input  logic              exitReq,
  output cfgStrobe_t        strb,
  output logic              cfgActive,
  output logic              altBase
);

  logic [1:0]        keyIdx;
  logic [7:0]        keyWant;
  logic              keyHit;
  logic [ADDR_W-1:0] idxAddr;
  logic [ADDR_W-1:0] dataAddr;

  always_comb begin
    case (keyIdx)
      2'd0:    keyWant = KEY_B0;
      2'd1:    keyWant = KEY_B1;
      default: keyWant = KEY_B2;
    endcase
    if (keyIdx == 2'd3) keyHit = (ioWdata == KEY_LOW) || (ioWdata == KEY_HIGH);
    else                keyHit = (ioWdata == keyWant);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgActive <= 1'b0;
      keyIdx    <= 2'd0;
      altBase   <= 1'b0;
    end else if (cfgActive) begin
      keyIdx <= 2'd0;
      if (exitReq) cfgActive <= 1'b0;
    end else if (ioWr && ioAddr == KEY_PORT) begin
      if (keyHit) begin
        if (keyIdx == 2'd3) begin
          cfgActive <= 1'b1;
          altBase   <= (ioWdata == KEY_HIGH);
          keyIdx    <= 2'd0;
        end else begin
          keyIdx <= keyIdx + 2'd1;
        end
      end else begin
        keyIdx <= (ioWdata == KEY_B0) ? 2'd1 : 2'd0;
      end
    end
  end

  assign idxAddr  = altBase ? ALT_PORT : KEY_PORT;
  assign dataAddr = idxAddr + ADDR_W'(1);

  assign strb.idxWr  = cfgActive && ioWr && (ioAddr == idxAddr);
  assign strb.idxRd  = cfgActive && ioRd && (ioAddr == idxAddr);
  assign strb.dataWr = cfgActive && ioWr && (ioAddr == dataAddr);
  assign strb.dataRd = cfgActive && ioRd && (ioAddr == dataAddr);

endmodule

// File: rtl/pnp_cfg_regs.sv
module pnp_cfg_regs
  import pnp_cfg_pkg::*;
#(
  parameter int NUM_DEV = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  cfgStrobe_t         strb,
  input  logic [7:0]         ioWdata,
  input  logic               jumperSel,
  output logic [7:0]         rdData,
  output logic               exitReq,
  output logic [7:0]         curIdx,
  output logic [NUM_DEV-1:0] devEnable,
  output logic               clkSel,
  output logic               suspendFlag
);

  localparam logic [7:0] DEV_LIMIT = 8'(NUM_DEV);

  logic [7:0] idxReg;
  logic [7:0] ldnReg;
  logic       csWritten;
  logic       csBit;
  logic       chipSel;
  logic       alwaysOpen;
  logic       wrEn;
  logic       bankWr;
  logic       ldnValid;
  logic       actSel;

  assign chipSel    = !csWritten || (csBit == jumperSel);
  assign alwaysOpen = (idxReg == IDX_CTRL) || (idxReg == IDX_CS);
  assign wrEn       = strb.dataWr && (chipSel || alwaysOpen);
  assign ldnValid   = ldnReg < DEV_LIMIT;
  assign bankWr     = wrEn && (idxReg == IDX_ACT) && ldnValid;
  assign exitReq    = strb.dataWr && (idxReg == IDX_CTRL) && (ioWdata == EXIT_CMD);
  assign curIdx     = idxReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxReg      <= 8'h00;
      ldnReg      <= 8'h00;
      csWritten   <= 1'b0;
      csBit       <= 1'b0;
      clkSel      <= 1'b0;
      suspendFlag <= 1'b1;
    end else begin
      if (strb.idxWr) idxReg <= ioWdata;
      if (wrEn) begin
        case (idxReg)
          IDX_LDN:  ldnReg <= ioWdata;
          IDX_CS: begin
            csWritten <= 1'b1;
            csBit     <= ioWdata[7];
          end
          IDX_CLK:  clkSel      <= ioWdata[0];
          IDX_SUSP: suspendFlag <= ioWdata[0];
          default: ;
        endcase
      end
    end
  end

  // one activate flop per logical device bank
  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    logic actQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                            actQ <= 1'b0;
      else if (bankWr && ldnReg == 8'(g))   actQ <= ioWdata[0];
    end
    assign devEnable[g] = actQ;
  end

  always_comb begin
    actSel = 1'b0;
    for (int k = 0; k < NUM_DEV; k++)
      if (ldnReg == 8'(k)) actSel = devEnable[k];
  end

  always_comb begin
    rdData = 8'hFF;
    if (strb.idxRd) begin
      rdData = idxReg;
    end else if (strb.dataRd && chipSel) begin
      case (idxReg)
        IDX_CTRL: rdData = 8'h00;
        IDX_LDN:  rdData = ldnReg;
        IDX_CS:   rdData = {csBit, 7'b0};
        IDX_CLK:  rdData = {7'b0, clkSel};
        IDX_SUSP: rdData = {7'b0, suspendFlag};
        IDX_ACT:  rdData = ldnValid ? {7'b0, actSel} : 8'hFF;
        default:  rdData = 8'hFF;
      endcase
    end
  end

endmodule

// File: rtl/pnp_cfg_port.sv
module pnp_cfg_port
  import pnp_cfg_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int NUM_DEV = 10,
  parameter logic [ADDR_W-1:0] KEY_PORT = 16'h002E,
  parameter logic [ADDR_W-1:0] ALT_PORT = 16'h004E
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  ioAddr,
  input  logic               ioWr,
  input  logic               ioRd,
  input  logic [7:0]         ioWdata,
  output logic [7:0]         ioRdata,
  input  logic               jumperSel,
  output logic [NUM_DEV-1:0] devEnable,
  output logic               cfgActive,
  output logic               clkSel,
  output logic               suspendFlag
);

  cfgStrobe_t strb;
  logic       exitReq;
  logic       altBase;
  logic [7:0] curIdx;

  pnp_cfg_ctrl #(
    .ADDR_W(ADDR_W), .KEY_PORT(KEY_PORT), .ALT_PORT(ALT_PORT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
    .ioWdata(ioWdata), .exitReq(exitReq), .strb(strb),
    .cfgActive(cfgActive), .altBase(altBase)
  );

  pnp_cfg_regs #(.NUM_DEV(NUM_DEV)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .ioWdata(ioWdata),
    .jumperSel(jumperSel), .rdData(ioRdata), .exitReq(exitReq),
    .curIdx(curIdx), .devEnable(devEnable), .clkSel(clkSel),
    .suspendFlag(suspendFlag)
  );

endmodule

// File: rtl/pnp_cfg_port_chk.sv
module pnp_cfg_port_chk #(
  parameter int ADDR_W  = 16,
  parameter int NUM_DEV = 10,
  parameter logic [ADDR_W-1:0] KEY_PORT = 16'h002E,
  parameter logic [ADDR_W-1:0] ALT_PORT = 16'h004E
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  ioAddr,
  input logic               ioWr,
  input logic               ioRd,
  input logic [7:0]         ioWdata,
  input logic [7:0]         ioRdata,
  input logic [NUM_DEV-1:0] devEnable,
  input logic               cfgActive,
  input logic               altBase,
  input logic [7:0]         curIdx
);

  logic [ADDR_W-1:0] dataPort;
  assign dataPort = (altBase ? ALT_PORT : KEY_PORT) + ADDR_W'(1);

  // R1: configuration mode opens only on a valid final key byte at the key port
  p_unlock_key_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgActive) |-> $past(ioWr && ioAddr == KEY_PORT &&
                               (ioWdata == 8'h55 || ioWdata == 8'hAA)));

  // R4: no enable moves while locked
  p_locked_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !cfgActive |=> $stable(devEnable));

  // R4: locked reads float high
  p_locked_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgActive && ioRd) |-> ioRdata == 8'hFF);

  // R6: the exit command closes configuration mode
  p_exit_cmd_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgActive && ioWr && ioAddr == dataPort && curIdx == 8'h02 && ioWdata == 8'h02)
      |=> !cfgActive);

  // R10: reset leaves everything off and locked
  p_reset_state_r10: assert property (@(posedge clk)
    !rstN |=> (devEnable == '0 && !cfgActive));

endmodule

bind pnp_cfg_port pnp_cfg_port_chk #(
  .ADDR_W(ADDR_W), .NUM_DEV(NUM_DEV), .KEY_PORT(KEY_PORT), .ALT_PORT(ALT_PORT)
) u_chk (
  .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
  .ioWdata(ioWdata), .ioRdata(ioRdata), .devEnable(devEnable),
  .cfgActive(cfgActive), .altBase(altBase), .curIdx(curIdx)
);

// File: tb/tb_pnp_cfg_port.sv
module tb_pnp_cfg_port;

  localparam int NUM_DEV = 10;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [15:0]        ioAddr = '0;
  logic               ioWr = 1'b0;
  logic               ioRd = 1'b0;
  logic [7:0]         ioWdata = '0;
  logic [7:0]         ioRdata;
  logic               jumperSel = 1'b0;
  logic [NUM_DEV-1:0] devEnable;
  logic               cfgActive;
  logic               clkSel;
  logic               suspendFlag;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  pnp_cfg_port dut (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
    .ioWdata(ioWdata), .ioRdata(ioRdata), .jumperSel(jumperSel),
    .devEnable(devEnable), .cfgActive(cfgActive), .clkSel(clkSel),
    .suspendFlag(suspendFlag)
  );

  // op: 0 write, 1 read and compare, 2 compare cfgActive with val[0],
  //     3 compare devEnable[val[7:4]] with val[0]
  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] addr;
    logic [7:0]  val;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 63;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 16'h002F, 8'hFF, 4'd4},   // R4 locked read
    '{2'd0, 16'h002E, 8'h87, 4'd1},   // R1 key
    '{2'd0, 16'h002E, 8'h01, 4'd1},
    '{2'd0, 16'h002E, 8'h55, 4'd1},
    '{2'd0, 16'h002E, 8'h55, 4'd1},
    '{2'd2, 16'h0000, 8'h01, 4'd1},   // R1 open
    '{2'd1, 16'h002E, 8'h00, 4'd11},  // R11 index readback
    '{2'd0, 16'h002E, 8'h07, 4'd5},   // R5 device number
    '{2'd0, 16'h002F, 8'h03, 4'd5},
    '{2'd1, 16'h002F, 8'h03, 4'd5},
    '{2'd0, 16'h002E, 8'h30, 4'd5},   // R5 activate bank 3
    '{2'd0, 16'h002F, 8'h01, 4'd5},
    '{2'd3, 16'h0000, 8'h31, 4'd5},
    '{2'd1, 16'h002F, 8'h01, 4'd5},
    '{2'd0, 16'h002E, 8'h07, 4'd5},   // R5 bank 5
    '{2'd0, 16'h002F, 8'h05, 4'd5},
    '{2'd0, 16'h002E, 8'h30, 4'd5},
    '{2'd0, 16'h002F, 8'h01, 4'd5},
    '{2'd3, 16'h0000, 8'h51, 4'd5},
    '{2'd0, 16'h002E, 8'h40, 4'd9},   // R9 unimplemented index
    '{2'd1, 16'h002F, 8'hFF, 4'd9},
    '{2'd0, 16'h002E, 8'h07, 4'd9},   // R9 device 12 out of range
    '{2'd0, 16'h002F, 8'h0C, 4'd9},
    '{2'd0, 16'h002E, 8'h30, 4'd9},
    '{2'd1, 16'h002F, 8'hFF, 4'd9},
    '{2'd0, 16'h002F, 8'h01, 4'd9},
    '{2'd3, 16'h0000, 8'h00, 4'd9},
    '{2'd0, 16'h002E, 8'h02, 4'd6},   // R6 configure control
    '{2'd1, 16'h002F, 8'h00, 4'd6},
    '{2'd0, 16'h002F, 8'h01, 4'd6},
    '{2'd2, 16'h0000, 8'h01, 4'd6},
    '{2'd0, 16'h002F, 8'h02, 4'd6},
    '{2'd2, 16'h0000, 8'h00, 4'd6},
    '{2'd0, 16'h002F, 8'h09, 4'd4},   // R4 locked write
    '{2'd1, 16'h002F, 8'hFF, 4'd4},
    '{2'd0, 16'h002E, 8'h87, 4'd3},   // R3 repeated first byte
    '{2'd0, 16'h002E, 8'h01, 4'd3},
    '{2'd0, 16'h002E, 8'h87, 4'd3},
    '{2'd0, 16'h002E, 8'h01, 4'd3},
    '{2'd0, 16'h002E, 8'h55, 4'd3},
    '{2'd0, 16'h002E, 8'h55, 4'd3},
    '{2'd2, 16'h0000, 8'h01, 4'd3},
    '{2'd0, 16'h002E, 8'h02, 4'd6},
    '{2'd0, 16'h002F, 8'h02, 4'd6},
    '{2'd0, 16'h002E, 8'h87, 4'd3},   // R3 wrong third byte
    '{2'd0, 16'h002E, 8'h01, 4'd3},
    '{2'd0, 16'h002E, 8'h33, 4'd3},
    '{2'd0, 16'h002E, 8'h55, 4'd3},
    '{2'd0, 16'h002E, 8'h55, 4'd3},
    '{2'd2, 16'h0000, 8'h00, 4'd3},
    '{2'd0, 16'h002E, 8'h87, 4'd2},   // R2 alternate base
    '{2'd0, 16'h002E, 8'h01, 4'd2},
    '{2'd0, 16'h002E, 8'h55, 4'd2},
    '{2'd0, 16'h002E, 8'hAA, 4'd2},
    '{2'd2, 16'h0000, 8'h01, 4'd2},
    '{2'd0, 16'h004E, 8'h07, 4'd2},
    '{2'd1, 16'h004E, 8'h07, 4'd2},
    '{2'd1, 16'h002F, 8'hFF, 4'd2},
    '{2'd1, 16'h004F, 8'h0C, 4'd2},   // R4 device number kept through locked write
    '{2'd0, 16'h004E, 8'h02, 4'd6},
    '{2'd0, 16'h004F, 8'h02, 4'd6},
    '{2'd2, 16'h0000, 8'h00, 4'd6},
    '{2'd0, 16'h002E, 8'h87, 4'd2}    // start of a bad-final-byte key, finished below
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioWdata = d; ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic busRead(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioRd = 1'b1;
    #3;
    d = ioRdata;
    @(negedge clk);
    ioRd = 1'b0;
  endtask

  task automatic unlock(input logic [7:0] last);
    busWrite(16'h002E, 8'h87);
    busWrite(16'h002E, 8'h01);
    busWrite(16'h002E, 8'h55);
    busWrite(16'h002E, last);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(10, devEnable, 0);
    check(10, cfgActive, 0);
    check(10, clkSel, 0);
    check(10, suspendFlag, 1);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        2'd0: busWrite(VEC[i].addr, VEC[i].val);
        2'd1: begin
          busRead(VEC[i].addr, rd);
          check(VEC[i].req, rd, VEC[i].val);
        end
        2'd2: check(VEC[i].req, cfgActive, VEC[i].val[0]);
        default: check(VEC[i].req, devEnable[VEC[i].val[7:4]], VEC[i].val[0]);
      endcase
    end

    // R2 bad final byte keeps the block locked
    busWrite(16'h002E, 8'h01);
    busWrite(16'h002E, 8'h55);
    busWrite(16'h002E, 8'h11);
    check(2, cfgActive, 0);

    // R7 chip select against the jumper
    unlock(8'h55);
    busWrite(16'h002E, 8'h22);
    busWrite(16'h002F, 8'h80);
    busWrite(16'h002E, 8'h07);
    busWrite(16'h002F, 8'h04);
    busRead(16'h002F, rd);
    check(7, rd, 8'hFF);
    jumperSel = 1'b1;
    busRead(16'h002F, rd);
    check(7, rd, 8'h0C);
    busWrite(16'h002E, 8'h22);
    busWrite(16'h002F, 8'h00);
    busWrite(16'h002E, 8'h02);
    busWrite(16'h002F, 8'h02);
    check(7, cfgActive, 0);

    // R8 clock select and suspend flag
    unlock(8'h55);
    busWrite(16'h002E, 8'h22);
    busWrite(16'h002F, 8'h80);
    busWrite(16'h002E, 8'h23);
    busWrite(16'h002F, 8'h01);
    check(8, clkSel, 1);
    busWrite(16'h002E, 8'h24);
    busRead(16'h002F, rd);
    check(8, rd, 8'h01);
    busWrite(16'h002F, 8'h00);
    check(8, suspendFlag, 0);
    busRead(16'h002F, rd);
    check(8, rd, 8'h00);

    // R10 reset in the middle of configuration
    busWrite(16'h002E, 8'h07);
    busWrite(16'h002F, 8'h02);
    busWrite(16'h002E, 8'h30);
    busWrite(16'h002F, 8'h01);
    check(5, devEnable[2], 1);
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(10, devEnable, 0);
    check(10, cfgActive, 0);
    check(10, clkSel, 0);
    check(10, suspendFlag, 1);
    unlock(8'h55);
    busWrite(16'h002E, 8'h07);
    busRead(16'h002F, rd);
    check(10, rd, 8'h00);

    finishRun();
  end

endmodule